// File: doc/BRIEF.md
# Hashed Row-Lookup Search Engine

This block finds a search key in a table that is held in an ordinary RAM array instead of a content-addressable array. A hash folds the key down to a row number. Only that one row is read, and every key slot in the row is compared with the search key at once. Keys that did not fit in their row live in a small fully associative spill store. The spill store is searched alongside the row read, so a spilled key costs no extra time.

Searches enter on a valid/ready request channel, one per cycle. They pass through four registered stages: hashing, row read, slot compare and result output. Each result leaves on a valid/ready response channel, in request order. It carries a hit flag, a flag that says whether the spill store supplied the hit, the matching slot number and the hashed row number. When the response is not taken, the whole pipeline holds.

The table is loaded through a one-entry-per-cycle write port. The write port can also invalidate entries. An occupancy output gives the number of valid entries, so the table's fill level can be watched.

Top module: `hashed_row_search`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` is 0, `req_ready` is 1 and `occ_count` is 0.
- R2: The reported row is the XOR fold of the key: row bit j is the XOR of every key bit i for which i mod ROW_BITS equals j.
- R3: A key that is stored in a valid slot of its hashed row gives `rsp_hit`=1, `rsp_ovf`=0 and `rsp_idx` equal to that slot. If the key sits in several slots of the row, the lowest slot number is reported.
- R4: A slot or spill entry written with `wr_vld`=0 never matches, whatever key it holds.
- R5: A write with `wr_ovf`=1 loads spill entry `wr_idx`. A key found only in the spill store gives `rsp_hit`=1, `rsp_ovf`=1 and `rsp_idx` equal to the lowest matching spill entry, with the same latency as a row hit.
- R6: When both the row and the spill store hold the key, the row result is reported (`rsp_ovf`=0).
- R7: A key found nowhere gives `rsp_hit`=0, `rsp_ovf`=0 and `rsp_idx`=0, and still reports its hashed row.
- R8: A request accepted on a clock edge has its response valid after the third following edge, which is the fourth cycle after the request cycle. Requests can be accepted back to back, and responses come out in request order.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold still and `req_ready` is 0. No request is lost or duplicated.
- R10: A write made in the cycle in which a lookup is in its row-read stage is seen by that lookup. With no stall, this is the cycle right after the lookup is accepted.
- R11: `occ_count` equals the number of valid row slots plus valid spill entries, and it changes on the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Search request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_key | input | KEY_W | Search key |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Key found |
| rsp_ovf | output | 1 | Hit came from the spill store |
| rsp_idx | output | IDX_W | Matching slot or spill entry |
| rsp_row | output | ROW_BITS | Hashed row of the key |
| wr_en | input | 1 | Table write strobe |
| wr_ovf | input | 1 | 1 selects the spill store, 0 the row array |
| wr_row | input | ROW_BITS | Row written (row array only) |
| wr_idx | input | IDX_W | Slot or spill entry written |
| wr_key | input | KEY_W | Key written |
| wr_vld | input | 1 | Valid bit written |
| occ_count | output | CNT_W | Number of valid entries |

## Verification
A response is due exactly three clock edges after the edge that accepts its request, provided the consumer does not stall. The occupancy count is due on the same edge as the write it reflects. The bench records the edge count at each acceptance, samples on falling edges and compares every response with the expectation at the head of its queue. Without stalls it requires the edge difference to be exactly three, and it flags a response that is missing at that point. With stalls it requires the difference to be at least three, and the fields are compared again on every held cycle. The forwarding case writes on the edge after acceptance, so the expectation for that lookup already includes the write.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

    // XOR fold: output bit (i mod rb) accumulates key bit i
    function automatic logic [31:0] fold_key(input logic [63:0] key, input int kw, input int rb);
        logic [31:0] h;
        h = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < kw) h[5'(i % rb)] = h[5'(i % rb)] ^ key[i];
        end
        return h;
    endfunction

endpackage

// File: rtl/lkp_row_store.sv
module lkp_row_store #(
    parameter int KEY_W    = 16,
    parameter int ROW_BITS = 4,
    parameter int SLOTS    = 4,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int OCC_W   = $clog2(ROWS * SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ROW_BITS-1:0]       wr_row,
    input  logic [SLOT_W-1:0]         wr_slot,
    input  logic [KEY_W-1:0]          wr_key,
    input  logic                      wr_vld,
    input  logic [ROW_BITS-1:0]       rd_row,
    output logic [SLOTS*KEY_W-1:0]    rd_keys,
    output logic [SLOTS-1:0]          rd_vld,
    output logic [OCC_W-1:0]          occ
);
    logic [KEY_W-1:0] key_q [ROWS][SLOTS];
    logic [SLOTS-1:0] vld_q [ROWS];
    logic [SLOTS-1:0] vld_d [ROWS];

    always_comb begin
        for (int r = 0; r < ROWS; r++) vld_d[r] = vld_q[r];
        if (wr_en) vld_d[wr_row][wr_slot] = wr_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) vld_q[r] <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) vld_q[r] <= vld_d[r];
        end
    end

    // key storage carries no reset; only the valid bits matter
    always_ff @(posedge clk) begin
        if (wr_en) key_q[wr_row][wr_slot] <= wr_key;
    end

    // row read with same-cycle write forwarding
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            if (wr_en && wr_row == rd_row && int'(wr_slot) == s) begin
                rd_keys[s*KEY_W +: KEY_W] = wr_key;
                rd_vld[s]                 = wr_vld;
            end else begin
                rd_keys[s*KEY_W +: KEY_W] = key_q[rd_row][s];
                rd_vld[s]                 = vld_q[rd_row][s];
            end
        end
    end

    always_comb begin
        occ = '0;
        for (int r = 0; r < ROWS; r++)
            for (int s = 0; s < SLOTS; s++)
                occ = occ + OCC_W'(vld_q[r][s]);
    end
endmodule

// File: rtl/lkp_ovf_store.sv
module lkp_ovf_store #(
    parameter int KEY_W = 16,
    parameter int DEPTH = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_vld,
    input  logic [KEY_W-1:0] srch_key,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output logic [OCC_W-1:0] occ
);
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] vld_q, vld_d;

    always_comb begin
        vld_d = vld_q;
        if (wr_en) vld_d[wr_idx] = wr_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) key_q[wr_idx] <= wr_key;
    end

    // parallel search with write forwarding, lowest entry wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            logic [KEY_W-1:0] k;
            logic             v;
            if (wr_en && int'(wr_idx) == e) begin
                k = wr_key;
                v = wr_vld;
            end else begin
                k = key_q[e];
                v = vld_q[e];
            end
            if (v && k == srch_key) begin
                hit     = 1'b1;
                hit_idx = IW'(e);
            end
        end
    end

    assign occ = OCC_W'($countones(vld_q));
endmodule

// File: rtl/lkp_row_match.sv
module lkp_row_match #(
    parameter int KEY_W = 16,
    parameter int SLOTS = 4,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS*KEY_W-1:0] keys,
    input  logic [SLOTS-1:0]       vld,
    input  logic [KEY_W-1:0]       key,
    output logic                   hit,
    output logic [SLOT_W-1:0]      slot
);
    logic [SLOTS-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_cmp
            assign eq[g] = vld[g] && (keys[g*KEY_W +: KEY_W] == key);
        end
    endgenerate

    always_comb begin
        hit  = |eq;
        slot = '0;
        for (int s = SLOTS - 1; s >= 0; s--)
            if (eq[s]) slot = SLOT_W'(s);
    end
endmodule

// File: rtl/hashed_row_search.sv
module hashed_row_search #(
    parameter int KEY_W     = 16,
    parameter int ROW_BITS  = 4,
    parameter int SLOTS     = 4,
    parameter int OVF_DEPTH = 4,
    localparam int ROWS     = 1 << ROW_BITS,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int OVF_W    = $clog2(OVF_DEPTH),
    localparam int IDX_W    = (SLOT_W > OVF_W) ? SLOT_W : OVF_W,
    localparam int ROCC_W   = $clog2(ROWS * SLOTS + 1),
    localparam int OOCC_W   = $clog2(OVF_DEPTH + 1),
    localparam int CNT_W    = $clog2(ROWS * SLOTS + OVF_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [KEY_W-1:0]    req_key,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic                rsp_hit,
    output logic                rsp_ovf,
    output logic [IDX_W-1:0]    rsp_idx,
    output logic [ROW_BITS-1:0] rsp_row,
    input  logic                wr_en,
    input  logic                wr_ovf,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [KEY_W-1:0]    wr_key,
    input  logic                wr_vld,
    output logic [CNT_W-1:0]    occ_count
);
    import lkp_pkg::*;

    typedef struct packed {
        // stage 1: hashed index
        logic                   s1_v;
        logic [KEY_W-1:0]       s1_key;
        logic [ROW_BITS-1:0]    s1_row;
        // stage 2: row and spill read
        logic                   s2_v;
        logic [KEY_W-1:0]       s2_key;
        logic [ROW_BITS-1:0]    s2_row;
        logic [SLOTS*KEY_W-1:0] s2_keys;
        logic [SLOTS-1:0]       s2_vld;
        logic                   s2_ohit;
        logic [OVF_W-1:0]       s2_oidx;
        // stage 3: matched
        logic                   s3_v;
        logic                   s3_hit;
        logic                   s3_ovf;
        logic [IDX_W-1:0]       s3_idx;
        logic [ROW_BITS-1:0]    s3_row;
        // stage 4: forwarded result
        logic                   o_v;
        logic                   o_hit;
        logic                   o_ovf;
        logic [IDX_W-1:0]       o_idx;
        logic [ROW_BITS-1:0]    o_row;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic                   adv;
    logic [SLOTS*KEY_W-1:0] rd_keys;
    logic [SLOTS-1:0]       rd_vld;
    logic                   ohit, rhit;
    logic [OVF_W-1:0]       oidx;
    logic [SLOT_W-1:0]      rslot;
    logic [ROCC_W-1:0]      row_occ;
    logic [OOCC_W-1:0]      ovf_occ;
    logic                   row_wr, ovf_wr;

    assign row_wr = wr_en && !wr_ovf && (int'(wr_idx) < SLOTS);
    assign ovf_wr = wr_en &&  wr_ovf && (int'(wr_idx) < OVF_DEPTH);

    lkp_row_store #(.KEY_W(KEY_W), .ROW_BITS(ROW_BITS), .SLOTS(SLOTS)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .wr_en(row_wr), .wr_row(wr_row), .wr_slot(wr_idx[SLOT_W-1:0]),
        .wr_key(wr_key), .wr_vld(wr_vld),
        .rd_row(pipe_q.s1_row), .rd_keys(rd_keys), .rd_vld(rd_vld), .occ(row_occ)
    );

    lkp_ovf_store #(.KEY_W(KEY_W), .DEPTH(OVF_DEPTH)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ovf_wr), .wr_idx(wr_idx[OVF_W-1:0]), .wr_key(wr_key), .wr_vld(wr_vld),
        .srch_key(pipe_q.s1_key), .hit(ohit), .hit_idx(oidx), .occ(ovf_occ)
    );

    lkp_row_match #(.KEY_W(KEY_W), .SLOTS(SLOTS)) u_match (
        .keys(pipe_q.s2_keys), .vld(pipe_q.s2_vld), .key(pipe_q.s2_key),
        .hit(rhit), .slot(rslot)
    );

    assign adv = !pipe_q.o_v || rsp_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (adv) begin
            pipe_d.o_v    = pipe_q.s3_v;
            pipe_d.o_hit  = pipe_q.s3_hit;
            pipe_d.o_ovf  = pipe_q.s3_ovf;
            pipe_d.o_idx  = pipe_q.s3_idx;
            pipe_d.o_row  = pipe_q.s3_row;

            pipe_d.s3_v   = pipe_q.s2_v;
            pipe_d.s3_row = pipe_q.s2_row;
            if (rhit) begin
                pipe_d.s3_hit = 1'b1;
                pipe_d.s3_ovf = 1'b0;
                pipe_d.s3_idx = IDX_W'(rslot);
            end else if (pipe_q.s2_ohit) begin
                pipe_d.s3_hit = 1'b1;
                pipe_d.s3_ovf = 1'b1;
                pipe_d.s3_idx = IDX_W'(pipe_q.s2_oidx);
            end else begin
                pipe_d.s3_hit = 1'b0;
                pipe_d.s3_ovf = 1'b0;
                pipe_d.s3_idx = '0;
            end

            pipe_d.s2_v    = pipe_q.s1_v;
            pipe_d.s2_key  = pipe_q.s1_key;
            pipe_d.s2_row  = pipe_q.s1_row;
            pipe_d.s2_keys = rd_keys;
            pipe_d.s2_vld  = rd_vld;
            pipe_d.s2_ohit = ohit;
            pipe_d.s2_oidx = oidx;

            pipe_d.s1_v   = req_valid;
            pipe_d.s1_key = req_key;
            pipe_d.s1_row = ROW_BITS'(fold_key(64'(req_key), KEY_W, ROW_BITS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign req_ready = adv;
    assign rsp_valid = pipe_q.o_v;
    assign rsp_hit   = pipe_q.o_hit;
    assign rsp_ovf   = pipe_q.o_ovf;
    assign rsp_idx   = pipe_q.o_idx;
    assign rsp_row   = pipe_q.o_row;
    assign occ_count = CNT_W'(row_occ) + CNT_W'(ovf_occ);

    // in-flight tally kept for the checks below
    logic [2:0] infl_d, infl_q;
    always_comb begin
        infl_d = infl_q + 3'(req_valid && req_ready) - 3'(rsp_valid && rsp_ready);
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) infl_q <= '0;
        else        infl_q <= infl_d;
    end

    // R8
    inflight_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        infl_q <= 3'd4);

    // R8
    rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> infl_q != 3'd0);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_ovf)
                                    && $stable(rsp_idx) && $stable(rsp_row));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    // R5
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ovf |-> rsp_hit);

    // R7
    miss_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_idx == '0);

    // R11
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (occ_count == $past(occ_count))
              || (occ_count == CNT_W'($past(occ_count) + 1'b1))
              || (CNT_W'(occ_count + 1'b1) == $past(occ_count)));
endmodule

// File: tb/sim_hashed_row_search.sv
module sim_hashed_row_search;
    localparam int KW = 16;
    localparam int RB = 4;
    localparam int NS = 4;
    localparam int NO = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [15:0] req_key = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1;
    logic        rsp_hit, rsp_ovf;
    logic [1:0]  rsp_idx;
    logic [3:0]  rsp_row;
    logic        wr_en = 0, wr_ovf = 0, wr_vld = 0;
    logic [3:0]  wr_row = '0;
    logic [1:0]  wr_idx = '0;
    logic [15:0] wr_key = '0;
    logic [6:0]  occ_count;

    hashed_row_search u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_ovf(rsp_ovf), .rsp_idx(rsp_idx), .rsp_row(rsp_row),
        .wr_en(wr_en), .wr_ovf(wr_ovf), .wr_row(wr_row), .wr_idx(wr_idx),
        .wr_key(wr_key), .wr_vld(wr_vld), .occ_count(occ_count)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit started = 0, exact = 1, occ_skip = 0, rnd = 0, done = 0;

    // reference table
    logic [15:0] mk [16][4];
    bit          mv [16][4];
    logic [15:0] ok [4];
    bit          ov [4];

    int eh_q[$], eo_q[$], ei_q[$], er_q[$], ea_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        if (rnd) rsp_ready <= ($urandom % 4) != 0;
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int hash4(input logic [15:0] k);
        logic [3:0] h;
        h = k[3:0] ^ k[7:4] ^ k[11:8] ^ k[15:12];
        return int'(h);
    endfunction

    function automatic int model_occ();
        int n = 0;
        for (int r = 0; r < 16; r++)
            for (int s = 0; s < NS; s++) if (mv[r][s]) n++;
        for (int e = 0; e < NO; e++) if (ov[e]) n++;
        return n;
    endfunction

    task automatic push_exp(input logic [15:0] k, input string tag);
        int r, h, o, ix;
        r = hash4(k); h = 0; o = 0; ix = 0;
        for (int s = NS - 1; s >= 0; s--)
            if (mv[r][s] && mk[r][s] == k) begin h = 1; ix = s; end
        if (h == 0)
            for (int e = NO - 1; e >= 0; e--)
                if (ov[e] && ok[e] == k) begin h = 1; o = 1; ix = e; end
        eh_q.push_back(h); eo_q.push_back(o); ei_q.push_back(ix);
        er_q.push_back(r); ea_q.push_back(cyc); tag_q.push_back(tag);
    endtask

    // monitor on the falling edge
    always @(negedge clk) begin
        if (rst_n && started) begin
            if (!occ_skip) chk("R11", int'(occ_count), model_occ(), "occupancy");
            if (rsp_valid) begin
                if (eh_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8 unexpected response actual 1 expected 0");
                end else begin
                    chk(tag_q[0], int'(rsp_hit), eh_q[0], "hit");
                    chk(tag_q[0], int'(rsp_ovf), eo_q[0], "spill flag");
                    chk(tag_q[0], int'(rsp_idx), ei_q[0], "index");
                    chk("R2", int'(rsp_row), er_q[0], "row");
                    if (exact) chk("R8", cyc - ea_q[0], 3, "latency");
                    else if (cyc - ea_q[0] < 3) chk("R8", cyc - ea_q[0], 3, "early response");
                    if (rsp_ready) begin
                        void'(eh_q.pop_front()); void'(eo_q.pop_front());
                        void'(ei_q.pop_front()); void'(er_q.pop_front());
                        void'(ea_q.pop_front()); void'(tag_q.pop_front());
                    end
                end
            end else if (exact && eh_q.size() > 0 && cyc - ea_q[0] >= 3) begin
                chk("R8", 0, 1, "missing response");
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic search(input logic [15:0] k, input string tag);
        bit rdy;
        req_valid = 1;
        req_key   = k;
        forever begin
            rdy = req_ready;
            tick();
            if (rdy) begin
                push_exp(k, tag);
                break;
            end
        end
    endtask

    task automatic idle();
        req_valid = 0;
    endtask

    task automatic wr(input bit to_ovf, input int row, input int idx, input logic [15:0] k, input bit v);
        wr_en = 1; wr_ovf = to_ovf; wr_row = 4'(row); wr_idx = 2'(idx); wr_key = k; wr_vld = v;
        tick();
        if (to_ovf) begin ok[idx] = k; ov[idx] = v; end
        else begin mk[row][idx] = k; mv[row][idx] = v; end
        wr_en = 0;
    endtask

    task automatic drain();
        while (eh_q.size() > 0) tick();
        tick();
    endtask

    initial begin
        for (int r = 0; r < 16; r++)
            for (int s = 0; s < NS; s++) begin mk[r][s] = '0; mv[r][s] = 0; end
        for (int e = 0; e < NO; e++) begin ok[e] = '0; ov[e] = 0; end

        repeat (3) tick();
        // R1 during reset
        chk("R1", int'(rsp_valid), 0, "rsp_valid in reset");
        chk("R1", int'(req_ready), 1, "req_ready in reset");
        chk("R1", int'(occ_count), 0, "occupancy in reset");
        rst_n = 1;
        tick();
        chk("R1", int'(rsp_valid), 0, "rsp_valid after reset");
        chk("R1", int'(req_ready), 1, "req_ready after reset");
        started = 1;

        // load row 5 full, spill entries
        wr(0, 5, 0, 16'h0005, 1);
        wr(0, 5, 1, 16'h1105, 1);
        wr(0, 5, 2, 16'h2205, 1);
        wr(0, 5, 3, 16'h3305, 1);
        wr(1, 0, 0, 16'h4405, 1);
        wr(1, 0, 1, 16'h1105, 1);
        wr(1, 0, 2, 16'h0707, 1);
        tick();

        // back-to-back searches, exact latency
        search(16'h0005, "R3");
        search(16'h1105, "R6");
        search(16'h2205, "R3");
        search(16'h3305, "R3");
        search(16'h4405, "R5");
        search(16'h0707, "R5");
        search(16'h9999, "R7");
        search(16'hA5C3, "R7");
        idle();
        drain();

        // invalidation and duplicate slots
        wr(0, 5, 2, 16'h2205, 0);
        wr(0, 5, 3, 16'h0005, 1);
        wr(1, 0, 0, 16'h4405, 0);
        tick();
        search(16'h2205, "R4");
        search(16'h0005, "R3");
        search(16'h4405, "R4");
        search(16'h3305, "R7");
        idle();
        drain();

        // same-cycle write forwarding into row 9
        req_valid = 1; req_key = 16'h0009;
        tick();
        occ_skip = 1;
        mk[9][0] = 16'h0009; mv[9][0] = 1;
        push_exp(16'h0009, "R10");
        req_valid = 0;
        wr_en = 1; wr_ovf = 0; wr_row = 4'd9; wr_idx = 2'd0; wr_key = 16'h0009; wr_vld = 1;
        tick();
        wr_en = 0; occ_skip = 0;
        drain();

        // stall with a full pipeline
        exact = 0;
        rsp_ready = 0;
        fork
            begin
                search(16'h0005, "R9");
                search(16'h1105, "R9");
                search(16'h0009, "R9");
                search(16'h0707, "R9");
                search(16'h1234, "R9");
                search(16'h3305, "R9");
                idle();
            end
            begin
                repeat (12) @(posedge clk);
                #1;
                chk("R9", int'(req_ready), 0, "req_ready while stalled");
                chk("R9", int'(rsp_valid), 1, "rsp_valid while stalled");
                rsp_ready = 1;
            end
        join
        drain();

        // random back-pressure over a mixed key pool
        rnd = 1;
        for (int i = 0; i < 60; i++) begin
            logic [15:0] k;
            case ($urandom % 6)
                0: k = 16'h0005;
                1: k = 16'h1105;
                2: k = 16'h0707;
                3: k = 16'h0009;
                4: k = 16'h3305;
                default: k = 16'($urandom);
            endcase
            search(k, "R8");
        end
        idle();
        repeat (20) tick();
        rnd = 0;
        #2 rsp_ready = 1;
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule